// File: doc/BRIEF.md
# Register Map Dump Serializer

This block answers a debug request to dump the register map as one byte stream. After a start pulse it sends a count byte. It then walks every peripheral address from module 0, index 0 up to module 5, index 0Dh, module by module with the index rising. After that it walks a fixed list of system registers. Each value it needs is fetched over a simple synchronous read port, and each byte leaves on a valid/ready output. A debug shift engine that is not part of this block takes the bytes from there.

Parameter masks describe each peripheral address: whether a register is implemented there, whether it is 16 bits wide, and whether reading it has side effects. Addresses with no register, or with side effects, produce zeros and are never read. Peripheral values always take two bytes. System values take one or two bytes by their own width. Reads are fetched one word ahead, so the stream carries one byte per cycle while ready stays high.

The controller has four states. `S_IDLE` goes to `S_HEADER` on start. `S_HEADER` sends the count byte and goes to `S_BODY` when that byte is accepted. `S_BODY` goes to `S_FINISH` when the last byte is accepted. `S_FINISH` pulses done and returns to `S_IDLE`.

Top module: `regmap_dump_serializer`

## Requirements
- R1: No byte is offered before start. The first byte after start is the peripheral count, 174 (0xAE).
- R2: Peripheral entries run from (module 0, index 0) to (module 5, index 0x0D), module-major with the index rising. Each entry is read at address {1'b0, module[2:0], index[4:0]} and sent as 16 bits, low byte first.
- R3: A peripheral register with index bit 2 clear is 8 bits wide. Its upper byte is sent as 0x00 whatever the read port returns in bits 15:8.
- R4: A peripheral address whose index has its low two bits equal to 3 has no register. It is sent as 0x0000 and is never read.
- R5: Index 9 in every module, and index 0 of module 3, have read side effects. They are sent as 0x0000 and no read strobe is raised for them.
- R6: System registers 0 to 39 follow the peripherals. Each is read at address {1'b1, 2'b00, k[5:0]}. Registers 0 to 23 are sent as two bytes, low first. Registers 24 to 39 are sent as one byte, the low byte.
- R7: Exactly 412 bytes follow the count byte. Done is high for one cycle, in the cycle after the last byte is accepted.
- R8: A start pulse during a dump is ignored. The stream and its single done pulse are unchanged.
- R9: While out_valid is high and out_ready is low, out_valid and out_data hold. No byte is lost or repeated under any ready pattern.
- R10: When ready stays high and read data returns one cycle after the strobe, the 413 bytes are accepted in 413 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a dump when idle |
| done | output | 1 | One-cycle pulse after the final byte is accepted |
| out_valid | output | 1 | Output byte present |
| out_ready | input | 1 | Consumer accepts the byte |
| out_data | output | 8 | Output byte |
| rd_en | output | 1 | Register read strobe |
| rd_addr | output | 9 | Read address: bit 8 selects system space |
| rd_valid | input | 1 | Read data present |
| rd_data | input | 16 | Read data |

## Verification
The assertions take for granted that the register port answers each strobe exactly once and keeps rd_valid low when no read is outstanding. The handshake checks assume the consumer does not care what out_data carries while out_valid is low. The bench's register model answers every strobe one cycle later with data derived from the address and raises rd_valid for nothing else. The bench changes out_ready only just after a clock edge, so the dump is observed under continuous, periodic and long-stall ready patterns while staying inside those assumptions.

// File: rtl/dump_pkg.sv
package dump_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_HEADER,
        S_BODY,
        S_FINISH
    } dump_state_e;

    typedef struct packed {
        logic [15:0] data;
        logic        two;
    } word_t;

    // flat peripheral position = module * 2**idx_w + index
    function automatic logic [255:0] mk_impl(int idx_w);
        logic [255:0] m;
        for (int i = 0; i < 256; i++) begin
            m[i] = ((i % (1 << idx_w)) % 4) != 3;
        end
        return m;
    endfunction

    function automatic logic [255:0] mk_wide(int idx_w);
        logic [255:0] m;
        for (int i = 0; i < 256; i++) begin
            m[i] = (((i % (1 << idx_w)) / 4) % 2) == 1;
        end
        return m;
    endfunction

    function automatic logic [255:0] mk_supp(int idx_w);
        logic [255:0] m;
        for (int i = 0; i < 256; i++) begin
            m[i] = ((i % (1 << idx_w)) == 9) ||
                   ((i / (1 << idx_w)) == 3 && (i % (1 << idx_w)) == 0);
        end
        return m;
    endfunction

    function automatic int sys_bytes(logic [63:0] wide, int n);
        int s;
        s = 0;
        for (int k = 0; k < 64; k++) begin
            if (k < n) s += wide[k] ? 2 : 1;
        end
        return s;
    endfunction

endpackage

// File: rtl/dump_walker.sv
module dump_walker #(
    parameter int MOD_W    = 3,
    parameter int IDX_W    = 5,
    parameter int LAST_MOD = 5,
    parameter int LAST_IDX = 13,
    parameter int NUM_SYS  = 40,
    parameter logic [63:0]  SYS_WIDE  = 64'h0000_0000_00FF_FFFF,
    parameter logic [255:0] IMPL_MASK = dump_pkg::mk_impl(IDX_W),
    parameter logic [255:0] WIDE_MASK = dump_pkg::mk_wide(IDX_W),
    parameter logic [255:0] SUPP_MASK = dump_pkg::mk_supp(IDX_W),
    localparam int ADDR_W = 1 + MOD_W + IDX_W,
    localparam int SYS_W  = $clog2(NUM_SYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              advance,
    output logic              more,
    output logic [ADDR_W-1:0] addr,
    output logic              zero,
    output logic              mask_hi,
    output logic              two
);
    logic             in_sys_q;
    logic             end_q;
    logic [MOD_W-1:0] mod_q;
    logic [IDX_W-1:0] idx_q;
    logic [SYS_W-1:0] sys_q;
    logic [MOD_W+IDX_W-1:0] flat;

    assign flat = {mod_q, idx_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_sys_q <= 1'b0;
            end_q    <= 1'b0;
            mod_q    <= '0;
            idx_q    <= '0;
            sys_q    <= '0;
        end else if (restart) begin
            in_sys_q <= 1'b0;
            end_q    <= 1'b0;
            mod_q    <= '0;
            idx_q    <= '0;
            sys_q    <= '0;
        end else if (advance) begin
            if (!in_sys_q) begin
                if (mod_q == MOD_W'(LAST_MOD) && idx_q == IDX_W'(LAST_IDX)) begin
                    in_sys_q <= 1'b1;
                end else if (idx_q == '1) begin
                    idx_q <= '0;
                    mod_q <= mod_q + MOD_W'(1);
                end else begin
                    idx_q <= idx_q + IDX_W'(1);
                end
            end else if (sys_q == SYS_W'(NUM_SYS - 1)) begin
                end_q <= 1'b1;
            end else begin
                sys_q <= sys_q + SYS_W'(1);
            end
        end
    end

    assign more    = !end_q;
    assign addr    = in_sys_q ? {1'b1, {(ADDR_W - 1 - SYS_W){1'b0}}, sys_q}
                              : {1'b0, mod_q, idx_q};
    assign zero    = !in_sys_q && (!IMPL_MASK[flat] || SUPP_MASK[flat]);
    assign mask_hi = !in_sys_q && !WIDE_MASK[flat];
    assign two     = in_sys_q ? SYS_WIDE[sys_q] : 1'b1;

endmodule

// File: rtl/dump_fetch.sv
module dump_fetch (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                enable,
    input  logic                more,
    input  logic                zero,
    input  logic                mask_hi,
    input  logic                two,
    input  logic                take,
    input  logic                rd_valid,
    input  logic [15:0]         rd_data,
    output logic                rd_en,
    output logic                advance,
    output logic                sup_vld,
    output dump_pkg::word_t     sup
);
    import dump_pkg::*;

    logic  pend_q, pzero_q, pmask_q, ptwo_q;
    logic  nxt_vld_q, nxt_vld_d;
    word_t nxt_q, nxt_d, in_w;
    logic  in_vld, taken, issue;

    always_comb begin
        in_vld    = pend_q && (pzero_q || rd_valid);
        in_w.two  = ptwo_q;
        if (pzero_q)      in_w.data = 16'h0000;
        else if (pmask_q) in_w.data = {8'h00, rd_data[7:0]};
        else              in_w.data = rd_data;
        sup_vld   = nxt_vld_q || in_vld;
        sup       = nxt_vld_q ? nxt_q : in_w;
        taken     = take && sup_vld;
        if (nxt_vld_q) nxt_vld_d = taken ? in_vld : 1'b1;
        else           nxt_vld_d = in_vld && !taken;
        nxt_d     = (nxt_vld_q && !taken) ? nxt_q : in_w;
        issue     = enable && more && (!pend_q || in_vld) && !nxt_vld_d;
        rd_en     = issue && !zero;
        advance   = issue;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pzero_q   <= 1'b0;
            pmask_q   <= 1'b0;
            ptwo_q    <= 1'b0;
            nxt_vld_q <= 1'b0;
            nxt_q     <= '0;
        end else if (restart) begin
            pend_q    <= 1'b0;
            nxt_vld_q <= 1'b0;
        end else begin
            nxt_vld_q <= nxt_vld_d;
            nxt_q     <= nxt_d;
            if (issue) begin
                pend_q  <= 1'b1;
                pzero_q <= zero;
                pmask_q <= mask_hi;
                ptwo_q  <= two;
            end else if (in_vld) begin
                pend_q  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dump_byte_out.sv
module dump_byte_out (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            sup_vld,
    input  dump_pkg::word_t sup,
    input  logic            fire,
    output logic            cur_vld,
    output logic [7:0]      cur_byte,
    output logic            take
);
    import dump_pkg::*;

    word_t cur_q;
    logic  vld_q, hi_q, word_done;

    assign word_done = fire && (!cur_q.two || hi_q);
    assign take      = !vld_q || word_done;
    assign cur_vld   = vld_q;
    assign cur_byte  = hi_q ? cur_q.data[15:8] : cur_q.data[7:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            hi_q  <= 1'b0;
            cur_q <= '0;
        end else if (restart) begin
            vld_q <= 1'b0;
            hi_q  <= 1'b0;
        end else if (take) begin
            vld_q <= sup_vld;
            cur_q <= sup;
            hi_q  <= 1'b0;
        end else if (fire) begin
            hi_q  <= 1'b1;
        end
    end

endmodule

// File: rtl/regmap_dump_serializer.sv
module regmap_dump_serializer #(
    parameter int MOD_W    = 3,
    parameter int IDX_W    = 5,
    parameter int LAST_MOD = 5,
    parameter int LAST_IDX = 13,
    parameter int NUM_SYS  = 40,
    parameter logic [63:0]  SYS_WIDE  = 64'h0000_0000_00FF_FFFF,
    parameter logic [255:0] IMPL_MASK = dump_pkg::mk_impl(IDX_W),
    parameter logic [255:0] WIDE_MASK = dump_pkg::mk_wide(IDX_W),
    parameter logic [255:0] SUPP_MASK = dump_pkg::mk_supp(IDX_W),
    localparam int ADDR_W = 1 + MOD_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [15:0]       rd_data
);
    import dump_pkg::*;

    localparam int PER_CNT    = LAST_MOD * (2 ** IDX_W) + LAST_IDX + 1;
    localparam int BODY_BYTES = 2 * PER_CNT + sys_bytes(SYS_WIDE, NUM_SYS);
    localparam int CNT_W      = $clog2(BODY_BYTES + 1);

    dump_state_e      state_q, state_d;
    logic [CNT_W-1:0] bcnt_q;
    logic             restart, enable, body_fire, last_fire;
    logic             more, zero, mask_hi, two, advance;
    logic             sup_vld, take, cur_vld;
    logic [7:0]       cur_byte;
    word_t            sup;

    assign restart   = (state_q == S_FINISH);
    assign enable    = (state_q == S_IDLE && start) || state_q == S_HEADER ||
                       state_q == S_BODY;
    assign last_fire = body_fire && bcnt_q == CNT_W'(BODY_BYTES - 1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            bcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_HEADER) bcnt_q <= '0;
            else if (body_fire)      bcnt_q <= bcnt_q + CNT_W'(1);
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start)     state_d = S_HEADER;
            S_HEADER: if (out_ready) state_d = S_BODY;
            S_BODY:   if (last_fire) state_d = S_FINISH;
            S_FINISH:                state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        out_valid = 1'b0;
        out_data  = 8'h00;
        done      = 1'b0;
        body_fire = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_HEADER: begin
                out_valid = 1'b1;
                out_data  = 8'(PER_CNT);
            end
            S_BODY: begin
                out_valid = cur_vld;
                out_data  = cur_byte;
                body_fire = cur_vld && out_ready;
            end
            S_FINISH: done = 1'b1;
        endcase
    end

    dump_walker #(
        .MOD_W(MOD_W), .IDX_W(IDX_W), .LAST_MOD(LAST_MOD), .LAST_IDX(LAST_IDX),
        .NUM_SYS(NUM_SYS), .SYS_WIDE(SYS_WIDE), .IMPL_MASK(IMPL_MASK),
        .WIDE_MASK(WIDE_MASK), .SUPP_MASK(SUPP_MASK)
    ) u_walk (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
        .more(more), .addr(rd_addr), .zero(zero), .mask_hi(mask_hi), .two(two)
    );

    dump_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .restart(restart), .enable(enable),
        .more(more), .zero(zero), .mask_hi(mask_hi), .two(two), .take(take),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_en(rd_en),
        .advance(advance), .sup_vld(sup_vld), .sup(sup)
    );

    dump_byte_out u_out (
        .clk(clk), .rst_n(rst_n), .restart(restart), .sup_vld(sup_vld),
        .sup(sup), .fire(body_fire), .cur_vld(cur_vld), .cur_byte(cur_byte),
        .take(take)
    );

endmodule

// File: rtl/dump_checker.sv
module dump_checker #(
    parameter int MOD_W    = 3,
    parameter int IDX_W    = 5,
    parameter int LAST_MOD = 5,
    parameter int LAST_IDX = 13,
    parameter int NUM_SYS  = 40,
    parameter logic [255:0] IMPL_MASK = '0,
    parameter logic [255:0] SUPP_MASK = '0,
    localparam int ADDR_W = 1 + MOD_W + IDX_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              out_valid,
    input logic              out_ready,
    input logic [7:0]        out_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr
);
    logic                   sys_sp;
    logic [MOD_W+IDX_W-1:0] flat;
    assign sys_sp = rd_addr[ADDR_W-1];
    assign flat   = rd_addr[MOD_W+IDX_W-1:0];

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_no_unimpl_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !sys_sp |-> IMPL_MASK[flat]);

    p_no_side_effect_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !sys_sp |-> !SUPP_MASK[flat]);

    p_periph_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !sys_sp |->
            int'(flat) <= LAST_MOD * (2 ** IDX_W) + LAST_IDX);

    p_sys_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && sys_sp |-> int'(flat) < NUM_SYS);

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(out_valid && out_ready));

endmodule

bind regmap_dump_serializer dump_checker #(
    .MOD_W(MOD_W), .IDX_W(IDX_W), .LAST_MOD(LAST_MOD), .LAST_IDX(LAST_IDX),
    .NUM_SYS(NUM_SYS), .IMPL_MASK(IMPL_MASK), .SUPP_MASK(SUPP_MASK)
) u_dump_chk (
    .clk(clk), .rst_n(rst_n), .done(done), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .rd_en(rd_en), .rd_addr(rd_addr)
);

// File: tb/tb_regmap_dump_serializer.sv
module tb_regmap_dump_serializer;
    localparam int TOTAL = 413;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        done, out_valid, rd_en;
    logic        out_ready = 1'b1;
    logic [7:0]  out_data;
    logic [8:0]  rd_addr;
    logic        rd_valid = 1'b0;
    logic [15:0] rd_data = 16'h0000;

    int checks = 0, errors = 0;
    int cyc = 0, mode = 0;
    int n, done_cnt, reads, bad_unimpl, bad_supp, first_cyc, last_cyc, done_cyc;
    logic [7:0] exp_b [TOTAL];
    string      exp_tag [TOTAL];
    logic [7:0] got [TOTAL];
    int exp_reads;
    logic prev_stall = 1'b0;
    logic [7:0] prev_data = 8'h00;

    regmap_dump_serializer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] model(logic [8:0] a);
        return {a[7:0] ^ 8'hA5, a[7:0] ^ {a[8], 7'h19}};
    endfunction

    // register model: answers one cycle after each strobe
    always @(posedge clk) begin
        rd_valid <= rd_en;
        rd_data  <= model(rd_addr);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ready patterns, applied just after each edge
    initial forever begin
        @(posedge clk);
        #1;
        case (mode)
            1:       out_ready = (cyc % 3) != 1;
            2:       out_ready = ((cyc / 7) % 2) == 0;
            default: out_ready = 1'b1;
        endcase
    end

    // monitor, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(out_valid && out_data == prev_data, "R9 hold",
                      {out_valid, out_data}, {1'b1, prev_data});
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (n < TOTAL) got[n] = out_data;
                if (n == 0) first_cyc = cyc;
                last_cyc = cyc;
                n++;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
            if (rd_en) begin
                reads++;
                if (!rd_addr[8] && rd_addr[1:0] == 2'd3) bad_unimpl++;
                if (!rd_addr[8] && (rd_addr[4:0] == 5'd9 ||
                    (rd_addr[7:5] == 3'd3 && rd_addr[4:0] == 5'd0))) bad_supp++;
            end
        end
    end

    task automatic build_expected();
        int p;
        p = 0;
        exp_reads = 0;
        exp_b[p] = 8'hAE; exp_tag[p] = "R1"; p++;
        for (int m = 0; m < 6; m++) begin
            for (int i = 0; i < 32; i++) begin
                if (!(m == 5 && i > 13)) begin
                    logic [15:0] d, v;
                    logic impl, supp;
                    string tg;
                    d    = model({1'b0, 3'(m), 5'(i)});
                    impl = (i % 4) != 3;
                    supp = (i == 9) || (m == 3 && i == 0);
                    if (!impl)     begin v = 16'h0; tg = "R4"; end
                    else if (supp) begin v = 16'h0; tg = "R5"; end
                    else if (((i / 4) % 2) == 0) begin v = {8'h00, d[7:0]}; tg = "R3"; end
                    else begin v = d; tg = "R2"; end
                    if (impl && !supp) exp_reads++;
                    exp_b[p] = v[7:0];  exp_tag[p] = tg; p++;
                    exp_b[p] = v[15:8]; exp_tag[p] = tg; p++;
                end
            end
        end
        for (int k = 0; k < 40; k++) begin
            logic [15:0] d;
            d = model({1'b1, 2'b00, 6'(k)});
            exp_reads++;
            exp_b[p] = d[7:0]; exp_tag[p] = "R6"; p++;
            if (k < 24) begin exp_b[p] = d[15:8]; exp_tag[p] = "R6"; p++; end
        end
        check(p == TOTAL, "R7 expected length", p, TOTAL);
    endtask

    task automatic run_dump(input int md);
        int t;
        mode = md;
        n = 0; done_cnt = 0; reads = 0; bad_unimpl = 0; bad_supp = 0;
        first_cyc = 0; last_cyc = 0; done_cyc = 0;
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        t = 0;
        while (done_cnt == 0 && t < 20000) begin
            @(posedge clk);
            t++;
            if (md == 0 && t == 60) begin
                #1 start = 1'b1;   // R8: start while busy
                @(posedge clk);
                #1 start = 1'b0;
                t++;
            end
        end
        repeat (8) @(posedge clk);
        check(n == TOTAL, "R7 byte count", n, TOTAL);
        check(done_cnt == 1, md == 0 ? "R8 done pulses" : "R7 done pulses", done_cnt, 1);
        check(done_cyc == last_cyc + 1, "R7 done timing", done_cyc, last_cyc + 1);
        check(bad_unimpl == 0, "R4 no read of empty address", bad_unimpl, 0);
        check(bad_supp == 0, "R5 no read of side-effect register", bad_supp, 0);
        check(reads == exp_reads, "R5 read count", reads, exp_reads);
        for (int i = 0; i < TOTAL; i++) begin
            if (i < n)
                check(got[i] == exp_b[i], md == 0 ? exp_tag[i] : "R9 stream",
                      got[i], exp_b[i]);
        end
        if (md == 0)
            check(last_cyc - first_cyc + 1 == TOTAL, "R10 span",
                  last_cyc - first_cyc + 1, TOTAL);
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        build_expected();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(!out_valid && !done && !rd_en, "R1 idle before start",
              {out_valid, done, rd_en}, 0);
        run_dump(0);
        run_dump(1);
        run_dump(2);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule